// File: doc/BRIEF.md
# Pulse-width single-wire battery-monitor host

This block is the host end of a single open-drain wire to a battery monitor. Bits are coded by how long the line is held low. An internal prescaler turns the system clock into a sample tick, nominally 20 us, and every timing in the block is a whole number of ticks. A request is a one-cycle `start` strobe that carries a 7-bit register address, a write flag and, for a write, one data byte. The block then produces the whole exchange on the wire. For a write that is a break, a recovery gap, the command byte, a pause and the data byte. For a read it is a break, a recovery gap and the command byte, after which the block releases the wire and times the monitor's reply bit by bit.

The wire is never driven high. `line_drive_low` enables an external low driver, and `line_in` returns the wire level, which an external pull-up holds high when nobody pulls it down. That level passes through a two-flop synchronizer before it is looked at, and it is only looked at on ticks. One `done` pulse closes every request, with a 2-bit code: 0 for success, 1 when the monitor never answered, 2 when a received low phase ran too long, and 3 when the gap between received bits ran too long.

The controller is one state machine with these states:
- IDLE
- BREAK (line low)
- RECOVER (line released)
- TX_LOW and TX_HIGH (the two halves of a sent bit cell)
- WR_GAP (pause before the write byte)
- RX_WAIT (waiting for the first reply edge)
- RX_LOW and RX_HIGH (timing a received bit)

The transitions are:
- IDLE to BREAK on an accepted start.
- BREAK to RECOVER when the break count expires.
- RECOVER to TX_LOW when the recovery count expires.
- TX_LOW to TX_HIGH when the low count expires.
- TX_HIGH to TX_LOW while bits remain in the byte.
- TX_HIGH to WR_GAP after a write command byte.
- TX_HIGH to RX_WAIT after a read command byte.
- TX_HIGH to IDLE after the write data byte.
- WR_GAP to TX_LOW when the pause expires.
- RX_WAIT to RX_LOW when the line is seen low, or RX_WAIT to IDLE with code 1 on timeout.
- RX_LOW to RX_HIGH on a rising line with bits still to come, RX_LOW to IDLE on the eighth bit, or RX_LOW to IDLE with code 2 on an over-long low phase.
- RX_HIGH to RX_LOW on a falling line, or RX_HIGH to IDLE with code 3 on an over-long gap.

Top module: `pwlink_host`

## Requirements
- R1: After an accepted start, `line_drive_low` rises on the next clock edge and stays high for more than (BREAK_T-1) and at most BREAK_T ticks. The line is then released for exactly RECOV_T ticks before the first command bit.
- R2: The command byte is sent least significant bit first. Bits 6..0 of it are the captured address, and bit 7 is 1 for a write and 0 for a read.
- R3: In each sent bit cell, a 1 holds the line low for exactly ONE_LOW_T ticks and a 0 for exactly ZERO_LOW_T ticks. Consecutive cells start exactly CELL_T ticks apart, so the cell length does not depend on the bit value.
- R4: For a write, the data byte's first cell starts (CELL_T+WR_GAP_T) ticks after the command's last cell started. The data byte is sent LSB first with the R3 coding, and the request ends with code 0 and no further low pulses.
- R5: For a read, the block stops driving after the command byte. If the line is not seen low within RX_WAIT_T ticks, the request ends with code 1.
- R6: A received bit is 1 when the line was sampled low on at most ONE_MAX_T ticks (default 3), and 0 otherwise. Eight bits arrive LSB first, each entering at bit 7 of a right shift, and `rdata` holds the byte when the request ends with code 0.
- R7: If a received low phase is still low after more than FIRST_LIM_T samples (first bit) or NEXT_LIM_T samples (later bits), the request ends with code 2. A first bit low for 15 samples and a later bit low for 17 samples are therefore accepted as 0.
- R8: If the line stays high for GAP_LIM_T ticks between received bits, the request ends with code 3.
- R9: After reset, busy, done, error code and `line_drive_low` are all 0. `line_drive_low` is never set while not busy, and busy falls on the cycle done is raised.
- R10: Each accepted request raises done for exactly one cycle, whether it succeeds or fails.
- R11: Start is ignored while busy. Address, flag and write data are captured when start is accepted, and later changes to those inputs do not affect the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request strobe, accepted only when idle |
| addr | input | ADDR_W (7) | Register address |
| wr | input | 1 | 1 = write, 0 = read |
| wdata | input | ADDR_W+1 (8) | Byte to write |
| rdata | output | ADDR_W+1 (8) | Received byte, valid at done with code 0 |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 2 | Completion code: 0 ok, 1 no reply, 2 low too long, 3 gap too long |
| line_drive_low | output | 1 | Enable for the external low driver |
| line_in | input | 1 | Level of the wire |

## Verification
A bit counter or shift register that has drifted shows up on the wire within one bit cell. The result is a low pulse of the wrong length, or a cell that starts off its CELL_T grid. A wrong phase flag shows up at the end of the command byte, as a missing write pause or a read that never releases the line. On the receive side, a wrong low count or limit selection changes `rdata` or the completion code at the very next done. A state that fails to return to IDLE shows as busy staying high, or as a second done, long before the next request.

// File: rtl/pwlink_pkg.sv
package pwlink_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_BREAK,
        ST_RECOVER,
        ST_TX_LOW,
        ST_TX_HIGH,
        ST_WR_GAP,
        ST_RX_WAIT,
        ST_RX_LOW,
        ST_RX_HIGH
    } link_st_e;

    localparam logic [1:0] CODE_OK      = 2'd0;
    localparam logic [1:0] CODE_NOREPLY = 2'd1;
    localparam logic [1:0] CODE_LOWLONG = 2'd2;
    localparam logic [1:0] CODE_GAPLONG = 2'd3;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pwlink_tick.sv
module pwlink_tick #(
    parameter int DIV = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int TW = $clog2(DIV + 1);
    localparam logic [TW-1:0] LAST = TW'(DIV - 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + TW'(1);
        end
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/pwlink_sync.sv
module pwlink_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '1;
        end else begin
            stage_q <= {stage_q[STAGES-2:0], d};
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pwlink_rxshift.sv
module pwlink_rxshift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (en) begin
            q <= {din, q[W-1:1]};
        end
    end
endmodule

// File: rtl/pwlink_host.sv
module pwlink_host
    import pwlink_pkg::*;
#(
    parameter int TICK_DIV    = 1000,
    parameter int BREAK_T     = 11,
    parameter int RECOV_T     = 3,
    parameter int ONE_LOW_T   = 2,
    parameter int ZERO_LOW_T  = 6,
    parameter int CELL_T      = 10,
    parameter int WR_GAP_T    = 15,
    parameter int RX_WAIT_T   = 150,
    parameter int ONE_MAX_T   = 3,
    parameter int FIRST_LIM_T = 15,
    parameter int NEXT_LIM_T  = 20,
    parameter int GAP_LIM_T   = 50,
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [ADDR_W:0]   wdata,
    output logic [ADDR_W:0]   rdata,
    output logic              busy,
    output logic              done,
    output logic [1:0]        err,
    output logic              line_drive_low,
    input  logic              line_in
);
    localparam int DW   = ADDR_W + 1;
    localparam int BW   = $clog2(DW);
    localparam int MAXT = max_of(max_of(max_of(BREAK_T, RECOV_T), max_of(CELL_T, WR_GAP_T)),
                                 max_of(RX_WAIT_T, GAP_LIM_T));
    localparam int CW   = $clog2(MAXT + 1);
    localparam int LW   = $clog2(max_of(FIRST_LIM_T, NEXT_LIM_T) + 1);

    localparam logic [CW-1:0] C_ONE   = CW'(1);
    localparam logic [CW-1:0] C_BREAK = CW'(BREAK_T);
    localparam logic [CW-1:0] C_RECOV = CW'(RECOV_T);
    localparam logic [CW-1:0] C_LOW1  = CW'(ONE_LOW_T);
    localparam logic [CW-1:0] C_LOW0  = CW'(ZERO_LOW_T);
    localparam logic [CW-1:0] C_CELL  = CW'(CELL_T);
    localparam logic [CW-1:0] C_WGAP  = CW'(WR_GAP_T);
    localparam logic [CW-1:0] C_RWAIT = CW'(RX_WAIT_T);
    localparam logic [CW-1:0] C_GAP   = CW'(GAP_LIM_T);
    localparam logic [LW-1:0] L_ONE   = LW'(1);
    localparam logic [LW-1:0] L_ONEMX = LW'(ONE_MAX_T);
    localparam logic [LW-1:0] L_FIRST = LW'(FIRST_LIM_T);
    localparam logic [LW-1:0] L_NEXT  = LW'(NEXT_LIM_T);
    localparam logic [BW-1:0] B_LAST  = BW'(DW - 1);

    link_st_e        st_q, st_d;
    logic [CW-1:0]   cnt_q, cnt_d, cnt2_q, cnt2_d;
    logic [LW-1:0]   low_q, low_d;
    logic            first_q, first_d;
    logic [BW-1:0]   bit_q, bit_d;
    logic            dph_q, dph_d;
    logic [DW-1:0]   txsh_q, txsh_d;
    logic [DW-1:0]   cmd_q, wd_q;

    logic            tick, line_s;
    logic            accept;
    logic            cell_go;
    logic [DW-1:0]   cell_src;
    logic [CW-1:0]   cell_len;
    logic            rx_clr, rx_shift, rx_val;
    logic            fin;
    logic [1:0]      fin_code;

    pwlink_tick #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    pwlink_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (line_in),
        .q    (line_s)
    );

    pwlink_rxshift #(.W(DW)) u_rx (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (rx_clr),
        .en   (rx_shift),
        .din  (rx_val),
        .q    (rdata)
    );

    assign accept   = (st_q == ST_IDLE) && start;
    assign cell_len = cell_src[0] ? C_LOW1 : C_LOW0;

    // next-state and datapath decisions
    always_comb begin
        st_d     = st_q;
        cnt_d    = cnt_q;
        cnt2_d   = cnt2_q;
        low_d    = low_q;
        first_d  = first_q;
        bit_d    = bit_q;
        dph_d    = dph_q;
        txsh_d   = txsh_q;
        cell_go  = 1'b0;
        cell_src = txsh_q;
        rx_clr   = 1'b0;
        rx_shift = 1'b0;
        rx_val   = 1'b0;
        fin      = 1'b0;
        fin_code = CODE_OK;

        unique case (st_q)
            ST_IDLE: begin
                if (start) begin
                    st_d  = ST_BREAK;
                    cnt_d = C_BREAK;
                end
            end
            ST_BREAK: begin
                if (tick) begin
                    if (cnt_q == C_ONE) begin
                        st_d  = ST_RECOVER;
                        cnt_d = C_RECOV;
                    end else begin
                        cnt_d = cnt_q - C_ONE;
                    end
                end
            end
            ST_RECOVER: begin
                if (tick) begin
                    if (cnt_q == C_ONE) begin
                        cell_go  = 1'b1;
                        cell_src = cmd_q;
                        bit_d    = B_LAST;
                        dph_d    = 1'b0;
                    end else begin
                        cnt_d = cnt_q - C_ONE;
                    end
                end
            end
            ST_TX_LOW: begin
                if (tick) begin
                    if (cnt_q == C_ONE) begin
                        st_d = ST_TX_HIGH;
                    end else begin
                        cnt_d = cnt_q - C_ONE;
                    end
                end
            end
            ST_TX_HIGH: begin
                if (tick) begin
                    if (cnt2_q == C_ONE) begin
                        if (bit_q != '0) begin
                            cell_go  = 1'b1;
                            cell_src = txsh_q;
                            bit_d    = bit_q - BW'(1);
                        end else if (dph_q) begin
                            st_d = ST_IDLE;
                            fin  = 1'b1;
                        end else if (cmd_q[DW-1]) begin
                            st_d  = ST_WR_GAP;
                            cnt_d = C_WGAP;
                        end else begin
                            st_d  = ST_RX_WAIT;
                            cnt_d = C_RWAIT;
                        end
                    end else begin
                        cnt2_d = cnt2_q - C_ONE;
                    end
                end
            end
            ST_WR_GAP: begin
                if (tick) begin
                    if (cnt_q == C_ONE) begin
                        cell_go  = 1'b1;
                        cell_src = wd_q;
                        bit_d    = B_LAST;
                        dph_d    = 1'b1;
                    end else begin
                        cnt_d = cnt_q - C_ONE;
                    end
                end
            end
            ST_RX_WAIT: begin
                if (tick) begin
                    if (!line_s) begin
                        st_d    = ST_RX_LOW;
                        low_d   = L_ONE;
                        first_d = 1'b1;
                        bit_d   = B_LAST;
                        rx_clr  = 1'b1;
                    end else if (cnt_q == C_ONE) begin
                        st_d     = ST_IDLE;
                        fin      = 1'b1;
                        fin_code = CODE_NOREPLY;
                    end else begin
                        cnt_d = cnt_q - C_ONE;
                    end
                end
            end
            ST_RX_LOW: begin
                if (tick) begin
                    if (line_s) begin
                        rx_shift = 1'b1;
                        rx_val   = (low_q <= L_ONEMX);
                        if (bit_q == '0) begin
                            st_d = ST_IDLE;
                            fin  = 1'b1;
                        end else begin
                            st_d  = ST_RX_HIGH;
                            cnt_d = C_GAP;
                            bit_d = bit_q - BW'(1);
                        end
                    end else if (low_q == (first_q ? L_FIRST : L_NEXT)) begin
                        st_d     = ST_IDLE;
                        fin      = 1'b1;
                        fin_code = CODE_LOWLONG;
                    end else begin
                        low_d = low_q + L_ONE;
                    end
                end
            end
            ST_RX_HIGH: begin
                if (tick) begin
                    if (!line_s) begin
                        st_d    = ST_RX_LOW;
                        low_d   = L_ONE;
                        first_d = 1'b0;
                    end else if (cnt_q == C_ONE) begin
                        st_d     = ST_IDLE;
                        fin      = 1'b1;
                        fin_code = CODE_GAPLONG;
                    end else begin
                        cnt_d = cnt_q - C_ONE;
                    end
                end
            end
            default: st_d = ST_IDLE;
        endcase

        if (cell_go) begin
            st_d   = ST_TX_LOW;
            cnt_d  = cell_len;
            cnt2_d = C_CELL - cell_len;
            txsh_d = cell_src >> 1;
        end
    end

    // state register and working registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            cnt_q   <= '0;
            cnt2_q  <= '0;
            low_q   <= '0;
            first_q <= 1'b0;
            bit_q   <= '0;
            dph_q   <= 1'b0;
            txsh_q  <= '0;
            cmd_q   <= '0;
            wd_q    <= '0;
        end else begin
            st_q    <= st_d;
            cnt_q   <= cnt_d;
            cnt2_q  <= cnt2_d;
            low_q   <= low_d;
            first_q <= first_d;
            bit_q   <= bit_d;
            dph_q   <= dph_d;
            txsh_q  <= txsh_d;
            if (accept) begin
                cmd_q <= {wr, addr};
                wd_q  <= wdata;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy           <= 1'b0;
            done           <= 1'b0;
            err            <= CODE_OK;
            line_drive_low <= 1'b0;
        end else begin
            busy           <= (st_d != ST_IDLE);
            line_drive_low <= (st_d == ST_BREAK) || (st_d == ST_TX_LOW);
            done           <= fin;
            if (fin) begin
                err <= fin_code;
            end else if (accept) begin
                err <= CODE_OK;
            end
        end
    end
endmodule

// File: rtl/pwlink_host_chk.sv
module pwlink_host_chk
    import pwlink_pkg::*;
#(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic [1:0]    err,
    input logic          line_drive_low,
    input link_st_e      st,
    input logic [DW-1:0] cmd
);
    a_r9_release_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !line_drive_low);

    a_r9_busy_falls_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r11_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cmd));

    a_r5_released_in_rx: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RX_WAIT || st == ST_RX_LOW || st == ST_RX_HIGH) |-> !line_drive_low);

    a_r4_write_ends_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cmd[DW-1]) |-> (err == CODE_OK));
endmodule

bind pwlink_host pwlink_host_chk #(.DW(DW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .done          (done),
    .err           (err),
    .line_drive_low(line_drive_low),
    .st            (st_q),
    .cmd           (cmd_q)
);

// File: tb/test_pwlink_host.sv
`timescale 1ns/1ps
module test_pwlink_host;
    localparam int D      = 4;
    localparam int BRK    = 11;
    localparam int RCV    = 3;
    localparam int L1     = 2;
    localparam int L0     = 6;
    localparam int CELL   = 10;
    localparam int WGAP   = 15;
    localparam int RING   = 512;

    // [15] write flag, [14:8] address, [7:0] write byte or slave reply
    localparam logic [15:0] VEC [0:5] = '{16'h8000, 16'hFFFF, 16'hAAA5,
                                          16'h553C, 16'h0180, 16'h7EFF};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [6:0] addr = '0;
    logic       wr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       busy, done, line_drive_low;
    logic [1:0] err;
    logic       slave_low = 1'b0;
    logic       line;

    assign line = !(line_drive_low || slave_low);

    pwlink_host #(.TICK_DIV(D)) i_pwlink_host (
        .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .wr(wr),
        .wdata(wdata), .rdata(rdata), .busy(busy), .done(done), .err(err),
        .line_drive_low(line_drive_low), .line_in(line)
    );

    always #10 clk = ~clk;

    int total = 0;
    int bad = 0;
    int done_cnt = 0;
    int cyc = 0;
    int np = 0;
    int pst [RING];
    int pln [RING];
    int sl_low [8];
    logic prev_drv = 1'b0;

    // records every host low pulse: start cycle and length
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (done) done_cnt = done_cnt + 1;
        if (line_drive_low && !prev_drv) pst[np % RING] = cyc;
        if (!line_drive_low && prev_drv) begin
            pln[np % RING] = cyc - pst[np % RING];
            np = np + 1;
        end
        prev_drv = line_drive_low;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic int decode(input int first);
        int v = 0;
        for (int i = 0; i < 8; i++) begin
            int len = pln[(first + i) % RING];
            if (len == L1 * D) v = v | (1 << i);
            else if (len != L0 * D) return -1;
        end
        return v;
    endfunction

    function automatic int cells_ok(input int first);
        for (int i = 0; i < 7; i++) begin
            if (pst[(first + i + 1) % RING] - pst[(first + i) % RING] != CELL * D) return 0;
        end
        return 1;
    endfunction

    task automatic slave_go(input int base, input int nbits);
        while (np < base + 9) @(negedge clk);
        repeat (12 * D) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            slave_low = 1'b1;
            repeat (sl_low[i] * D) @(negedge clk);
            slave_low = 1'b0;
            repeat (3 * D) @(negedge clk);
        end
    endtask

    task automatic txn(input logic rw, input logic [6:0] a, input logic [7:0] d,
                       input int nbits, input bit poke, output int base, output int dc0);
        base = np;
        dc0  = done_cnt;
        fork
            begin
                @(negedge clk);
                addr = a; wr = rw; wdata = d; start = 1'b1;
                @(negedge clk);
                start = 1'b0; addr = ~a; wr = ~rw; wdata = ~d;
                if (poke) begin
                    repeat (40) @(negedge clk);
                    start = 1'b1;
                    @(negedge clk);
                    start = 1'b0;
                end
                do @(negedge clk); while (!done);
            end
            begin
                if (nbits > 0) slave_go(base, nbits);
            end
        join
    endtask

    task automatic frame_checks(input logic rw, input logic [6:0] a, input int base);
        int bl = pln[base % RING];
        check(bl > (BRK - 1) * D && bl <= BRK * D, "R1", "break length", bl, BRK * D);
        check(pst[(base + 1) % RING] - (pst[base % RING] + bl) == RCV * D, "R1", "recovery",
              pst[(base + 1) % RING] - (pst[base % RING] + bl), RCV * D);
        check(decode(base + 1) == int'({rw, a}), "R2", "command byte", decode(base + 1), int'({rw, a}));
        check(cells_ok(base + 1) == 1, "R3", "command cell spacing", cells_ok(base + 1), 1);
    endtask

    task automatic end_checks(input int dc0);
        @(negedge clk);
        check(done_cnt - dc0 == 1, "R10", "done pulses", done_cnt - dc0, 1);
        check(!done && !busy && !line_drive_low, "R9", "released after end",
              {done, busy, line_drive_low}, 0);
    endtask

    initial begin
        int base, dc0;
        repeat (3) @(negedge clk);
        check(!busy && !done && err == 2'd0 && !line_drive_low, "R9", "reset state",
              {busy, done, err, line_drive_low}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // table walk: writes and clean reads
        for (int v = 0; v < 6; v++) begin
            logic rw;
            logic [6:0] a;
            logic [7:0] d;
            rw = VEC[v][15]; a = VEC[v][14:8]; d = VEC[v][7:0];
            for (int i = 0; i < 8; i++) sl_low[i] = d[i] ? L1 : L0;
            txn(rw, a, d, rw ? 0 : 8, 1'b0, base, dc0);
            frame_checks(rw, a, base);
            if (rw) begin
                check(decode(base + 9) == int'(d), "R4", "data byte", decode(base + 9), d);
                check(cells_ok(base + 9) == 1, "R3", "data cell spacing", cells_ok(base + 9), 1);
                check(pst[(base + 9) % RING] - pst[(base + 8) % RING] == (CELL + WGAP) * D,
                      "R4", "write pause", pst[(base + 9) % RING] - pst[(base + 8) % RING],
                      (CELL + WGAP) * D);
                check(err == 2'd0 && np - base == 17, "R4", "write end code/pulses", err, 0);
            end else begin
                check(rdata == d && err == 2'd0, "R6", "read byte", rdata, d);
                check(np - base == 9, "R5", "line released during read", np - base, 9);
            end
            end_checks(dc0);
        end

        // R11: inputs flipped after start and a second start while busy
        txn(1'b1, 7'h2A, 8'hA5, 0, 1'b1, base, dc0);
        frame_checks(1'b1, 7'h2A, base);
        check(decode(base + 9) == 8'hA5, "R11", "captured write byte", decode(base + 9), 8'hA5);
        end_checks(dc0);
        repeat (40) @(negedge clk);
        check(!busy && done_cnt - dc0 == 1, "R11", "start while busy ignored", done_cnt - dc0, 1);

        // R6 / R7 boundaries: 15 samples first bit, 3 and 4 samples, 17 on a later bit
        sl_low = '{15, 3, 4, 17, 2, 2, 2, 2};
        txn(1'b0, 7'h11, 8'h00, 8, 1'b0, base, dc0);
        check(rdata == 8'hF2 && err == 2'd0, "R6", "threshold decode", rdata, 8'hF2);
        end_checks(dc0);

        // R7 first-bit limit
        sl_low = '{17, 2, 2, 2, 2, 2, 2, 2};
        txn(1'b0, 7'h12, 8'h00, 1, 1'b0, base, dc0);
        check(err == 2'd2, "R7", "first bit low too long", err, 2);
        end_checks(dc0);

        // R7 later-bit limit
        sl_low = '{2, 22, 2, 2, 2, 2, 2, 2};
        txn(1'b0, 7'h13, 8'h00, 2, 1'b0, base, dc0);
        check(err == 2'd2, "R7", "later bit low too long", err, 2);
        end_checks(dc0);

        // R8 gap timeout after three bits
        sl_low = '{2, 6, 2, 2, 2, 2, 2, 2};
        txn(1'b0, 7'h14, 8'h00, 3, 1'b0, base, dc0);
        check(err == 2'd3, "R8", "gap too long", err, 3);
        end_checks(dc0);

        // R5 no reply
        txn(1'b0, 7'h15, 8'h00, 0, 1'b0, base, dc0);
        check(err == 2'd1, "R5", "no reply code", err, 1);
        check(np - base == 9, "R5", "no drive while waiting", np - base, 9);
        end_checks(dc0);

        // code cleared by the next successful request
        for (int i = 0; i < 8; i++) sl_low[i] = L1;
        txn(1'b0, 7'h16, 8'h00, 8, 1'b0, base, dc0);
        check(err == 2'd0 && rdata == 8'hFF, "R6", "recovery after error", rdata, 8'hFF);
        end_checks(dc0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total = total + 1;
        bad = bad + 1;
        $display("FAIL R10 watchdog: actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule